// File: doc/BRIEF.md
# Look-Aside Read Cache Controller

This block is a direct-mapped read cache that sits beside main memory on a shared processor bus. It does not sit between them. A bus cycle starts with a one-cycle strobe, and the cache and the memory both see that strobe together. On a read that hits, the cache answers in that same cycle. It drives the data, raises its ready, and raises an abort so that memory drops its own access.

On a read that misses, the cache stays quiet and lets memory answer. When memory raises its ready, the cache captures the returned word into the indexed line. If the same read comes again, it hits.

Writes from any bus master are watched as they pass to memory. If the written word is held in the cache, the cached copy is updated in place, so no stale copy remains. One address window is non-cacheable. Reads inside it never hit and are never captured.

Each line holds one tag and a valid bit for each word. Capturing a word under a new tag evicts everything the line held before.

Top module: `lookaside_cache`

## Requirements
- R1: After reset every word is invalid, so the first read of any address misses. While the bus is idle, ready and abort stay low.
- R2: A read hit asserts ready and mem_abort, and puts the cached word on hit_rdata, all in the cycle where bus_start is high.
- R3: On a read miss the cache raises neither ready nor abort. The word that memory returns with mem_ready is captured, and the next read of that address hits with it. This holds even when mem_ready comes in the same cycle as bus_start.
- R4: Placement is direct-mapped. Address bits [3:2] select the word, bits [9:4] select one of 64 lines, and bits [31:10] are the tag. Capturing under a different tag on the same line evicts every word that line held.
- R5: Addresses in [NC_BASE, NC_END) never hit and are never captured. A write there changes nothing in the cache.
- R6: A write to a held word replaces the cached word with bus_wdata, so a later read hits with the new value. A write never asserts ready or abort.
- R7: A write to a word that is not held does not allocate it, so a later read of that word misses.
- R8: Words of one line are valid separately. Capturing a second word under the same tag keeps the first word valid, and words that were never captured still miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle strobe that starts a bus cycle, seen by cache and memory alike |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 32 | Byte address of the cycle |
| bus_wdata | input | 32 | Write data on the bus |
| mem_ready | input | 1 | Memory has ended the current cycle; for reads, mem_rdata is valid |
| mem_rdata | input | 32 | Read data driven by memory |
| hit_ready | output | 1 | Cache ends the read cycle (hit) |
| hit_rdata | output | 32 | Cached word on a hit, zero otherwise |
| mem_abort | output | 1 | Tells memory to abandon the current read |

## Verification
The hardest state to reach is a line whose tag changes while some of its words are still valid. When that happens, the words that were not re-captured must stop hitting. The stimulus fills one word under tag 4 and a second word under the same tag. It then captures under tag 5 on the same line, re-captures only the first word under tag 4, and reads the second word, which must now miss. The same table also mixes writes that do not allocate, writes that update a held word, writes into the non-cacheable window, and a miss answered with zero wait.

// File: rtl/lookaside_cache.sv
module lookaside_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int WORDS  = 4,
  parameter logic [ADDR_W-1:0] NC_BASE = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] NC_END  = 32'h000C_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              hit_ready,
  output logic [DATA_W-1:0] hit_rdata,
  output logic              mem_abort
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int WS_W  = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - WS_W - OFF_W;
  localparam int LO_W  = OFF_W;
  localparam int LO_I  = OFF_W + WS_W;
  localparam int LO_T  = OFF_W + WS_W + IDX_W;

  logic [LINES-1:0][WORDS-1:0] vld;
  logic [TAG_W-1:0]  tags [LINES];
  logic [DATA_W-1:0] dat  [LINES*WORDS];

  logic              pend;
  logic [ADDR_W-1:0] pend_addr;

  // address fields of the live bus cycle
  logic [WS_W-1:0]  b_w;
  logic [IDX_W-1:0] b_i;
  logic [TAG_W-1:0] b_t;
  logic             b_nc;
  assign b_w  = bus_addr[LO_W +: WS_W];
  assign b_i  = bus_addr[LO_I +: IDX_W];
  assign b_t  = bus_addr[LO_T +: TAG_W];
  assign b_nc = (bus_addr >= NC_BASE) && (bus_addr < NC_END);

  logic held;
  assign held = !b_nc && vld[b_i][b_w] && (tags[b_i] == b_t);

  logic rd_hit, rd_miss, wr_hit;
  assign rd_hit  = bus_start && !bus_wr && held;
  assign rd_miss = bus_start && !bus_wr && !held && !b_nc;
  assign wr_hit  = bus_start && bus_wr && held;

  assign hit_ready = rd_hit;
  assign mem_abort = rd_hit;
  assign hit_rdata = rd_hit ? dat[{b_i, b_w}] : '0;

  // snarf path: memory's answer to a cacheable read miss
  logic              snarf;
  logic [ADDR_W-1:0] s_addr;
  logic [WS_W-1:0]   s_w;
  logic [IDX_W-1:0]  s_i;
  logic [TAG_W-1:0]  s_t;
  logic              s_same;
  assign snarf  = mem_ready && (pend || rd_miss);
  assign s_addr = pend ? pend_addr : bus_addr;
  assign s_w    = s_addr[LO_W +: WS_W];
  assign s_i    = s_addr[LO_I +: IDX_W];
  assign s_t    = s_addr[LO_T +: TAG_W];
  assign s_same = (tags[s_i] == s_t) && (vld[s_i] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
    end else if (snarf) begin
      pend <= 1'b0;
    end else if (rd_miss) begin
      pend      <= 1'b1;
      pend_addr <= bus_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (snarf) begin
      if (s_same) vld[s_i][s_w] <= 1'b1;
      else begin
        vld[s_i]      <= '0;
        vld[s_i][s_w] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (snarf) begin
      tags[s_i]       <= s_t;
      dat[{s_i, s_w}] <= mem_rdata;
    end else if (wr_hit) begin
      dat[{b_i, b_w}] <= bus_wdata;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vld == '0));
  p_ready_only_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ready |-> (bus_start && !bus_wr));
  p_abort_with_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_abort |-> (hit_ready && bus_start));
  p_nc_never_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ready |-> !((bus_addr >= NC_BASE) && (bus_addr < NC_END)));
  p_fill_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snarf |=> vld[$past(s_i)][$past(s_w)]);
  p_write_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !snarf) |=> (dat[{$past(b_i), $past(b_w)}] == $past(bus_wdata)));
endmodule

// File: tb/tb_lookaside_cache.sv
`timescale 1ns/1ps
module tb_lookaside_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_start = 1'b0, bus_wr = 1'b0, mem_ready = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, mem_rdata = '0;
  logic        hit_ready, mem_abort;
  logic [31:0] hit_rdata;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  lookaside_cache dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .hit_ready(hit_ready), .hit_rdata(hit_rdata),
    .mem_abort(mem_abort));

  // {write, address, data, expect hit, expected read data}
  localparam int NV = 23;
  localparam logic [97:0] VEC [NV] = '{
    {1'b0, 32'h0000_1004, 32'h1111_1111, 1'b0, 32'h0},          // R1 cold miss
    {1'b0, 32'h0000_1004, 32'h0,         1'b1, 32'h1111_1111},  // R2 R3
    {1'b0, 32'h0000_1008, 32'h2222_2222, 1'b0, 32'h0},          // R8
    {1'b0, 32'h0000_1004, 32'h0,         1'b1, 32'h1111_1111},  // R8
    {1'b0, 32'h0000_1008, 32'h0,         1'b1, 32'h2222_2222},  // R8
    {1'b1, 32'h0000_1004, 32'h3333_3333, 1'b0, 32'h0},          // R6
    {1'b0, 32'h0000_1004, 32'h0,         1'b1, 32'h3333_3333},  // R6
    {1'b1, 32'h0000_100C, 32'h4444_4444, 1'b0, 32'h0},          // R7
    {1'b0, 32'h0000_100C, 32'h5555_5555, 1'b0, 32'h0},          // R7
    {1'b0, 32'h0000_100C, 32'h0,         1'b1, 32'h5555_5555},  // R3
    {1'b0, 32'h0000_1404, 32'h6666_6666, 1'b0, 32'h0},          // R4
    {1'b0, 32'h0000_1404, 32'h0,         1'b1, 32'h6666_6666},  // R4
    {1'b0, 32'h0000_1004, 32'h7777_7777, 1'b0, 32'h0},          // R4 evicted
    {1'b0, 32'h0000_1008, 32'h8888_8888, 1'b0, 32'h0},          // R4 siblings gone
    {1'b0, 32'h000A_0010, 32'h9999_9999, 1'b0, 32'h0},          // R5
    {1'b0, 32'h000A_0010, 32'hAAAA_AAAA, 1'b0, 32'h0},          // R5
    {1'b0, 32'h0000_2030, 32'hBBBB_BBBB, 1'b0, 32'h0},          // R3
    {1'b0, 32'h0000_2030, 32'h0,         1'b1, 32'hBBBB_BBBB},  // R3
    {1'b1, 32'h0000_2030, 32'hCCCC_CCCC, 1'b0, 32'h0},          // R6
    {1'b0, 32'h0000_2030, 32'h0,         1'b1, 32'hCCCC_CCCC},  // R6
    {1'b0, 32'h0000_1004, 32'h0,         1'b1, 32'h7777_7777},  // R4
    {1'b1, 32'h000A_0010, 32'hDDDD_DDDD, 1'b0, 32'h0},          // R5
    {1'b0, 32'h000A_0010, 32'hEEEE_EEEE, 1'b0, 32'h0}           // R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input bit wr, input logic [31:0] a, input logic [31:0] d,
                           input bit exp_hit, input logic [31:0] exp_d, input bit zero_wait,
                           input string req);
    @(negedge clk);
    bus_start = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    mem_ready = zero_wait; mem_rdata = d;
    #1;
    chk(hit_ready == exp_hit, req, {31'b0, hit_ready}, {31'b0, exp_hit});
    chk(mem_abort == exp_hit, req, {31'b0, mem_abort}, {31'b0, exp_hit});
    if (exp_hit) chk(hit_rdata == exp_d, req, hit_rdata, exp_d);
    @(negedge clk);
    bus_start = 1'b0; bus_wr = 1'b0;
    if (!exp_hit && !zero_wait) begin
      mem_ready = 1'b1; mem_rdata = d;
      @(negedge clk);
    end
    mem_ready = 1'b0; mem_rdata = '0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(hit_ready == 1'b0, "R1", {31'b0, hit_ready}, 32'h0);
    chk(mem_abort == 1'b0, "R1", {31'b0, mem_abort}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_cycle(VEC[i][97], VEC[i][96:65], VEC[i][64:33], VEC[i][32], VEC[i][31:0], 1'b0,
                $sformatf("vector %0d", i));
    end

    // R3 zero-wait memory answer in the start cycle
    bus_cycle(1'b0, 32'h0000_3040, 32'h1234_5678, 1'b0, 32'h0, 1'b1, "R3 zero-wait");
    bus_cycle(1'b0, 32'h0000_3040, 32'h0, 1'b1, 32'h1234_5678, 1'b0, "R3 zero-wait hit");

    // R1 reset mid-run clears all held words
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bus_cycle(1'b0, 32'h0000_1004, 32'h0BAD_0001, 1'b0, 32'h0, 1'b0, "R1 after reset");
    bus_cycle(1'b0, 32'h0000_3040, 32'h0BAD_0002, 1'b0, 32'h0, 1'b0, "R1 after reset");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule